// File: doc/BRIEF.md
# Interval Timer Bank

The block holds eight free-running 64-bit interval timers behind a word-addressed register port. Each timer has a pending limit, an active limit and a live count, all 64 bits wide. Software sees the limit and the count as two 32-bit words each. Every timer has its own run bit in a shared control word.

While it runs, a timer advances by one on each cycle in which the reference tick qualifier is high. The tick qualifier is nominally strobed at 66.67 MHz. When a timer meets its active limit on a tick, it restarts from zero and issues a one-cycle event. The events leave on a source vector for a downstream interrupt router. Timer i drives source line i+1. Line 0 belongs to a watchdog that sits elsewhere, so it is held low.

Reads are combinational from the current address. A 64-bit count can carry between two word reads. Software copes with this by reading the high word, then the low word, then the high word again, and it reads the low word a second time if the two high words differ.

Top module: `timer_bank`

## Requirements
- R1: After reset every count, pending limit, active limit and run bit is zero, `evt_src` is all zero, and every mapped word reads zero.
- R2: The control word is at word address 0x000. Bit 8+i is the run bit of timer i. All other bits of the control word read zero and are not stored.
- R3: The low word of timer i's limit is at 0x100+i and the high word is at 0x110+i. A read returns the last value written to that word.
- R4: The low word of timer i's live count is at 0x120+i and the high word is at 0x130+i. A write to a count word presets that half and wins over a tick in the same cycle.
- R5: A running timer whose count differs from its active limit adds one on each clock edge where `tick` is high. It holds its count when `tick` is low.
- R6: A running timer whose count equals its active limit on a ticking edge does two things. Its count returns to zero, and `evt_src[i+1]` is high for the single cycle after that edge. `evt_src[0]` is never asserted, and no event appears without a tick on the preceding edge.
- R7: A stopped timer keeps its count unchanged whatever `tick` does, and raises no event from the second edge after its run bit is cleared. While it is stopped, its active limit follows the written limit at once.
- R8: While a timer runs, a new limit value is accepted into the limit words but becomes the active limit only at the next reload to zero.
- R9: The count is one 64-bit register. A low-word wrap from 0xFFFFFFFF raises the high word by exactly one on the same edge.
- R10: Addresses outside the mapped words read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Reference tick qualifier; counts advance only when high |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 10 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| evt_src | output | 9 | Event source vector; bit i+1 pulses for timer i, bit 0 held low |

## Verification
A corrupted count or active limit appears at the ports in two ways. The count read-back shows it immediately. The spacing of that timer's events on `evt_src` shows it within one period. Confusion between the pending and active limit shows up as an event that comes one period too early or too late after a limit write while the timer runs. A broken carry shows up as a high count word that is stale by one right after the low word wraps. The bench tracks every timer's state each cycle, so each of these faults is caught within a cycle of the first wrong read or event.

// File: rtl/timer_bank_pkg.sv
`timescale 1ns/1ps
package timer_bank_pkg;
  localparam int TB_N_TMR  = 8;
  localparam int TB_DATA_W = 32;
  localparam int TB_ADDR_W = 10;
  // word addresses of the register groups
  localparam int CTRL_WORD  = 'h000;
  localparam int LIM_LO_OFS = 'h100;
  localparam int LIM_HI_OFS = 'h110;
  localparam int CNT_LO_OFS = 'h120;
  localparam int CNT_HI_OFS = 'h130;
  localparam int RUN_LSB    = 8;     // run bit of timer i sits at RUN_LSB+i
endpackage

// File: rtl/timer_unit.sv
`timescale 1ns/1ps
module timer_unit #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                run,
  input  logic                wr_lim_lo,
  input  logic                wr_lim_hi,
  input  logic                wr_cnt_lo,
  input  logic                wr_cnt_hi,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0] lim_o,
  output logic [2*DATA_W-1:0] cnt_o,
  output logic                evt_o
);
  localparam int CW = 2 * DATA_W;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_q, lim_d;   // active limit
  logic [CW-1:0] pend_q, pend_d; // last written limit
  logic          evt_q, evt_d;
  logic          pend_ce, cnt_ce, lim_ce;

  assign pend_ce = wr_lim_lo | wr_lim_hi;
  assign cnt_ce  = (run & tick) | wr_cnt_lo | wr_cnt_hi;
  assign lim_ce  = ~run | (tick & (cnt_q == lim_q));

  always_comb begin
    pend_d = pend_q;
    if (wr_lim_lo) pend_d[DATA_W-1:0]  = wdata;
    if (wr_lim_hi) pend_d[CW-1:DATA_W] = wdata;

    cnt_d = cnt_q;
    lim_d = lim_q;
    evt_d = 1'b0;
    if (!run) begin
      lim_d = pend_d;
    end else if (tick) begin
      if (cnt_q == lim_q) begin
        cnt_d = '0;
        lim_d = pend_d;
        evt_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (wr_cnt_lo) cnt_d[DATA_W-1:0]  = wdata;
    if (wr_cnt_hi) cnt_d[CW-1:DATA_W] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      pend_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      if (cnt_ce)  cnt_q  <= cnt_d;
      if (lim_ce)  lim_q  <= lim_d;
      if (pend_ce) pend_q <= pend_d;
      evt_q <= evt_d;
    end
  end

  assign lim_o = pend_q;
  assign cnt_o = cnt_q;
  assign evt_o = evt_q;
endmodule

// File: rtl/timer_regmap.sv
`timescale 1ns/1ps
module timer_regmap
  import timer_bank_pkg::*;
#(
  parameter int N_TMR  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  input  logic [N_TMR-1:0][2*DATA_W-1:0]  lim_i,
  input  logic [N_TMR-1:0][2*DATA_W-1:0]  cnt_i,
  output logic [N_TMR-1:0]                run_o,
  output logic [N_TMR-1:0]                wr_lim_lo,
  output logic [N_TMR-1:0]                wr_lim_hi,
  output logic [N_TMR-1:0]                wr_cnt_lo,
  output logic [N_TMR-1:0]                wr_cnt_hi,
  output logic [DATA_W-1:0]               rdata
);
  logic [N_TMR-1:0] run_q, run_d;
  logic             hit_ctrl, run_ce;
  logic [N_TMR-1:0] hit_ll, hit_lh, hit_cl, hit_ch;

  assign hit_ctrl = (addr == ADDR_W'(CTRL_WORD));

  for (genvar i = 0; i < N_TMR; i++) begin : g_dec
    assign hit_ll[i]    = (addr == ADDR_W'(LIM_LO_OFS + i));
    assign hit_lh[i]    = (addr == ADDR_W'(LIM_HI_OFS + i));
    assign hit_cl[i]    = (addr == ADDR_W'(CNT_LO_OFS + i));
    assign hit_ch[i]    = (addr == ADDR_W'(CNT_HI_OFS + i));
    assign wr_lim_lo[i] = wr_en & hit_ll[i];
    assign wr_lim_hi[i] = wr_en & hit_lh[i];
    assign wr_cnt_lo[i] = wr_en & hit_cl[i];
    assign wr_cnt_hi[i] = wr_en & hit_ch[i];
  end

  assign run_ce = wr_en & hit_ctrl;
  assign run_d  = wdata[RUN_LSB +: N_TMR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_ce) run_q <= run_d;
  end
  assign run_o = run_q;

  always_comb begin
    rdata = '0;
    if (hit_ctrl) rdata[RUN_LSB +: N_TMR] = run_q;
    for (int i = 0; i < N_TMR; i++) begin
      if (hit_ll[i]) rdata = lim_i[i][DATA_W-1:0];
      if (hit_lh[i]) rdata = lim_i[i][2*DATA_W-1:DATA_W];
      if (hit_cl[i]) rdata = cnt_i[i][DATA_W-1:0];
      if (hit_ch[i]) rdata = cnt_i[i][2*DATA_W-1:DATA_W];
    end
  end
endmodule

// File: rtl/timer_bank.sv
`timescale 1ns/1ps
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int N_TMR  = TB_N_TMR,
  parameter int DATA_W = TB_DATA_W,
  parameter int ADDR_W = TB_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [N_TMR:0]    evt_src
);
  logic [N_TMR-1:0][2*DATA_W-1:0] lim_w, cnt_w;
  logic [N_TMR-1:0] run_w, wll, wlh, wcl, wch, evt_w;

  timer_regmap #(.N_TMR(N_TMR), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_map (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .lim_i(lim_w), .cnt_i(cnt_w), .run_o(run_w),
    .wr_lim_lo(wll), .wr_lim_hi(wlh), .wr_cnt_lo(wcl), .wr_cnt_hi(wch),
    .rdata(rdata)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    timer_unit #(.DATA_W(DATA_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run_w[i]),
      .wr_lim_lo(wll[i]), .wr_lim_hi(wlh[i]),
      .wr_cnt_lo(wcl[i]), .wr_cnt_hi(wch[i]), .wdata(wdata),
      .lim_o(lim_w[i]), .cnt_o(cnt_w[i]), .evt_o(evt_w[i])
    );
  end

  // source line 0 is reserved for a watchdog outside this block
  assign evt_src = {evt_w, 1'b0};
endmodule

// File: rtl/timer_bank_chk.sv
`timescale 1ns/1ps
module timer_bank_chk
  import timer_bank_pkg::*;
#(
  parameter int N_TMR  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [N_TMR:0]    evt_src
);
  logic mapped;
  always_comb begin
    mapped = (addr == ADDR_W'(CTRL_WORD));
    for (int i = 0; i < N_TMR; i++) begin
      if (addr == ADDR_W'(LIM_LO_OFS + i) || addr == ADDR_W'(LIM_HI_OFS + i) ||
          addr == ADDR_W'(CNT_LO_OFS + i) || addr == ADDR_W'(CNT_HI_OFS + i))
        mapped = 1'b1;
    end
  end

  a_r6_src0_idle: assert property (@(posedge clk) disable iff (!rst_n)
    evt_src[0] == 1'b0);

  a_r6_evt_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_src) |-> $past(tick));

  a_r2_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(CTRL_WORD)) |->
      (rdata[RUN_LSB-1:0] == '0 && rdata[DATA_W-1:RUN_LSB+N_TMR] == '0));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (rdata == '0));

  for (genvar i = 0; i < N_TMR; i++) begin : g_stop
    a_r7_stop_silences: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(CTRL_WORD) && !wdata[RUN_LSB+i]) |=> ##1 !evt_src[i+1]);
  end
endmodule

bind timer_bank timer_bank_chk #(.N_TMR(N_TMR), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .evt_src(evt_src)
);

// File: tb/tb_timer_bank.sv
`timescale 1ns/1ps
module tb_timer_bank;
  localparam int N = 8;

  logic        clk, rst_n, tick, wr_en;
  logic [9:0]  addr;
  logic [31:0] wdata, rdata;
  logic [8:0]  evt_src;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [63:0] m_cnt [N];
  logic [63:0] m_pend[N];
  logic [63:0] m_lim [N];
  logic [7:0]  m_run;
  logic [8:0]  m_evt;

  timer_bank dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                  .addr(addr), .wdata(wdata), .rdata(rdata), .evt_src(evt_src));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] m_read(input logic [9:0] a);
    logic [31:0] r = '0;
    if (a == 10'h000) r[15:8] = m_run;
    for (int i = 0; i < N; i++) begin
      if (a == 10'h100 + 10'(i)) r = m_pend[i][31:0];
      if (a == 10'h110 + 10'(i)) r = m_pend[i][63:32];
      if (a == 10'h120 + 10'(i)) r = m_cnt[i][31:0];
      if (a == 10'h130 + 10'(i)) r = m_cnt[i][63:32];
    end
    return r;
  endfunction

  task automatic m_next(input logic we, input logic [9:0] a, input logic [31:0] d, input logic tk);
    logic [7:0] run_new = m_run;
    m_evt = '0;
    if (we && a == 10'h000) run_new = d[15:8];
    for (int i = 0; i < N; i++) begin
      if (we && a == 10'h100 + 10'(i)) m_pend[i][31:0]  = d;
      if (we && a == 10'h110 + 10'(i)) m_pend[i][63:32] = d;
      if (!m_run[i]) m_lim[i] = m_pend[i];
      else if (tk) begin
        if (m_cnt[i] == m_lim[i]) begin
          m_cnt[i] = '0; m_lim[i] = m_pend[i]; m_evt[i+1] = 1'b1;
        end else m_cnt[i] = m_cnt[i] + 64'd1;
      end
      if (we && a == 10'h120 + 10'(i)) m_cnt[i][31:0]  = d;
      if (we && a == 10'h130 + 10'(i)) m_cnt[i][63:32] = d;
    end
    m_run = run_new;
  endtask

  // one cycle: drive at falling edge, check read, advance model, check events
  task automatic step(input logic we, input logic [9:0] a, input logic [31:0] d,
                      input logic tk, input string tag);
    logic [31:0] exp_r;
    wr_en = we; addr = a; wdata = d; tick = tk;
    #1;
    exp_r = m_read(a);
    checks++;
    if (rdata !== exp_r) begin
      errors++;
      $display("FAIL %s rdata addr=%h got=%h exp=%h", tag, a, rdata, exp_r);
    end
    m_next(we, a, d, tk);
    @(posedge clk); @(negedge clk);
    checks++;
    if (evt_src !== m_evt) begin
      errors++;
      $display("FAIL %s evt_src got=%b exp=%b", tag, evt_src, m_evt);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got=hang exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    for (int i = 0; i < N; i++) begin m_cnt[i] = '0; m_pend[i] = '0; m_lim[i] = '0; end
    m_run = '0; m_evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: everything cleared after reset
    checks++;
    if (evt_src !== 9'd0) begin errors++; $display("FAIL R1 evt_src got=%b exp=0", evt_src); end
    step(0, 10'h000, 0, 0, "R1");
    for (int i = 0; i < N; i++) begin
      step(0, 10'h100 + 10'(i), 0, 1, "R1");
      step(0, 10'h130 + 10'(i), 0, 1, "R1");
    end

    // R2: only the run bits are stored
    step(1, 10'h000, 32'hFFFF_FFFF, 0, "R2");
    step(0, 10'h000, 0, 0, "R2");
    checks++;
    if (rdata !== 32'h0000_FF00) begin errors++; $display("FAIL R2 ctrl got=%h exp=0000ff00", rdata); end
    step(1, 10'h000, 0, 0, "R2");

    // R3: limit words read back
    step(1, 10'h103, 32'hA5A5_0003, 0, "R3");
    step(1, 10'h113, 32'h1234_5678, 0, "R3");
    step(0, 10'h103, 0, 0, "R3");
    step(0, 10'h113, 0, 0, "R3");
    step(1, 10'h103, 0, 0, "R3");
    step(1, 10'h113, 0, 0, "R3");

    // R4: count preset, write beats tick
    step(1, 10'h000, 32'h0000_0400, 0, "R4");
    step(1, 10'h122, 32'h55, 1, "R4");
    step(0, 10'h122, 0, 0, "R4");
    checks++;
    if (rdata !== 32'h55) begin errors++; $display("FAIL R4 cnt got=%h exp=00000055", rdata); end

    // R5/R6: timer1 limit 3, events every fourth tick
    step(1, 10'h000, 32'h0, 0, "R6");
    step(1, 10'h122, 32'h0, 0, "R6");
    step(1, 10'h101, 32'd3, 0, "R6");
    step(1, 10'h000, 32'h0000_0200, 0, "R6");
    for (int k = 0; k < 12; k++) step(0, 10'h121, 0, 1, "R6");
    for (int k = 0; k < 3; k++) step(0, 10'h121, 0, 0, "R5");

    // R8: new limit while running takes effect at next reload
    step(1, 10'h101, 32'd6, 1, "R8");
    for (int k = 0; k < 20; k++) step(0, 10'h121, 0, 1, "R8");

    // R7: stopped timer holds, limit loads at once
    step(1, 10'h000, 32'h0, 1, "R7");
    for (int k = 0; k < 5; k++) step(0, 10'h121, 0, 1, "R7");
    step(1, 10'h101, 32'd1, 1, "R7");
    step(1, 10'h121, 32'd0, 0, "R7");
    step(1, 10'h000, 32'h0000_0200, 0, "R7");
    for (int k = 0; k < 6; k++) step(0, 10'h121, 0, 1, "R7");

    // R9: carry from low to high word
    step(1, 10'h000, 32'h0, 0, "R9");
    step(1, 10'h100, 32'hFFFF_FFFF, 0, "R9");
    step(1, 10'h110, 32'hFFFF_FFFF, 0, "R9");
    step(1, 10'h120, 32'hFFFF_FFFE, 0, "R9");
    step(1, 10'h130, 32'h0000_0005, 0, "R9");
    step(1, 10'h000, 32'h0000_0100, 0, "R9");
    step(0, 10'h130, 0, 1, "R9");
    step(0, 10'h120, 0, 1, "R9");
    step(0, 10'h130, 0, 0, "R9");
    checks++;
    if (rdata !== 32'h6) begin errors++; $display("FAIL R9 hi got=%h exp=00000006", rdata); end
    step(0, 10'h120, 0, 0, "R9");
    checks++;
    if (rdata !== 32'h0) begin errors++; $display("FAIL R9 lo got=%h exp=00000000", rdata); end

    // R10: unmapped words read zero, writes ignored
    step(1, 10'h108, 32'hDEAD_BEEF, 0, "R10");
    step(1, 10'h3FF, 32'hDEAD_BEEF, 0, "R10");
    step(0, 10'h108, 0, 0, "R10");
    step(0, 10'h100, 0, 0, "R10");

    // random mix of writes, reads and ticks
    step(1, 10'h000, 32'h0, 0, "R5");
    for (int i = 0; i < N; i++) begin
      step(1, 10'h110 + 10'(i), 0, 0, "R3");
      step(1, 10'h130 + 10'(i), 0, 0, "R4");
      step(1, 10'h120 + 10'(i), 0, 0, "R4");
    end
    for (int k = 0; k < 3000; k++) begin
      logic        we  = ($urandom % 4) == 0;
      int          sel = $urandom % 6;
      logic [9:0]  a;
      logic [31:0] d   = $urandom % 16;
      logic [9:0]  ix  = 10'($urandom % N);
      case (sel)
        0: begin a = 10'h000; d = $urandom; end
        1: a = 10'h100 + ix;
        2: begin a = 10'h110 + ix; d = 0; end
        3: a = 10'h120 + ix;
        4: begin a = 10'h130 + ix; d = 0; end
        default: begin a = 10'($urandom); we = 1'b0; end
      endcase
      step(we, a, d, ($urandom % 4) != 0, "R6");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule